// File: doc/BRIEF.md
# Multiphase Buck Phase-Count Controller

This block decides how many phases of a multiphase buck regulator switch at any moment. Each cycle it may take in a digitized total-current sample. It folds the sample into a first-order running average and compares that average against a table of per-phase-count boundaries. It drives a thermometer-coded enable vector in which phase 0 is always on. A separate fast peak-current flag bypasses the average and asks for every allowed phase.

Adding and removing phases behave differently. When the average falls below the boundary of the current count, less a hysteresis margin, the block removes one phase. It then waits a programmable dwell before it removes the next one. On a transient it turns phases on one after another, in index order and at a programmable stagger interval, so they do not all start in the same cycle. Each phase that has just been enabled starts from a reduced pulse-width command. That command climbs linearly to full duty, which limits overshoot and ringback while the new phase's inductor current builds. Any add request cancels a shed that is in progress.

Top module: `phase_count_ctrl`

## Requirements
- R1: After reset only phase 0 is enabled (`ph_en` = 000001), phase 0's pulse-width command is all ones, and every other command is 0.
- R2: Decisions use the average `avg += (smp - avg) >>> k`, where k is `k_sel` clamped to the range 2..8. With k = 8 (or a `k_sel` of 15, clamped to 8), a single sample of 1000 among samples of 30 adds no phase when the boundaries are 20/40.
- R3: Boundary field i of `thr_tbl` (bits [i*IW +: IW]) separates i+1 phases from i+2 phases. With n phases on and n below the maximum, an average above field n-1 adds one phase, and the count rises by at most one per cycle.
- R4: When `peak_i` is sampled high below the maximum, the next phase is enabled in the cycle right after that edge. Further phases follow in index order, one every `stagger_len`+1 cycles, until the clamped maximum is reached.
- R5: With n ≥ 2 phases on, when avg + `hyst` < field n-2, one phase is removed after `dwell_len`+1 consecutive cycles of that condition. Successive removals are spaced by exactly `dwell_len`+1 cycles, and each removal lowers the count by exactly one.
- R6: With boundaries 20/40/60/80/100 and hysteresis 4, a steady average of 30 settles at two phases, whether the count approaches from below or from above.
- R7: An add request (peak flag, or average above the boundary) in a cycle where a removal is due raises the count by one instead, and it restarts the dwell.
- R8: The number of enabled phases never exceeds `max_ph` clamped to 1..NPH, and a lowered limit takes effect in the same cycle. A `max_ph` of 0 acts as 1, and a value above NPH acts as NPH.
- R9: In its first enabled cycle a phase's command equals `init_pw`. The command then rises by `ramp_step` each cycle and saturates at all ones. A disabled phase's command is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Current sample valid this cycle |
| smp | input | IW | Total load-current sample |
| peak_i | input | 1 | Fast peak-current flag |
| k_sel | input | KW | Averaging shift, clamped to 2..8 |
| thr_tbl | input | (NPH-1)*IW | Phase-count boundaries, field i between i+1 and i+2 phases |
| hyst | input | IW | Hysteresis margin below a boundary for removal |
| max_ph | input | CW | Maximum phase count, clamped to 1..NPH |
| dwell_len | input | DW | Dwell between removal steps, minus one |
| stagger_len | input | DW | Interval between staggered adds, minus one |
| init_pw | input | PW | Starting pulse-width command of a new phase |
| ramp_step | input | PW | Per-cycle pulse-width increment |
| ph_en | output | NPH | Per-phase enable, thermometer code from phase 0 |
| ph_pw | output | NPH*PW | Per-phase pulse-width command, phase i at [i*PW +: PW] |

## Verification
Two functions can fall in the same cycle: a removal that has become due, and an add request. The bench sets the dwell to zero so that a removal is due on every cycle of a descent from six phases. It raises the peak flag at the moment it sees the count step from five to four. The outcome is judged one cycle later: a count of five shows the add took priority, and three would show the removal won. The bench also lowers the phase limit while all phases are on and expects the enable vector to shrink before the next clock edge.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_ADD  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/pc_avg_filter.sv
module pc_avg_filter #(
  parameter int IW = 12,
  parameter int KW = 4,
  parameter int FB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [IW-1:0] smp,
  input  logic [KW-1:0] k_sel,
  output logic [IW-1:0] avg
);
  localparam int AW = IW + FB;

  logic signed [AW:0] acc_q, acc_n, diff, stp;
  logic [KW-1:0]      k_eff;

  always_comb begin
    if (k_sel < KW'(2))      k_eff = KW'(2);
    else if (k_sel > KW'(8)) k_eff = KW'(8);
    else                     k_eff = k_sel;
    diff  = $signed({1'b0, smp, {FB{1'b0}}}) - acc_q;
    stp   = diff >>> k_eff;
    acc_n = smp_vld ? (acc_q + stp) : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end

  assign avg = acc_q[AW-1:FB];

  // R2
  toward_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && (smp > avg)) |=> (avg >= $past(avg)));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_pkg::*;
#(
  parameter int NPH = 6,
  parameter int IW  = 12,
  parameter int DW  = 8,
  parameter int CW  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IW-1:0]         avg,
  input  logic [(NPH-1)*IW-1:0] thr_tbl,
  input  logic [IW-1:0]         hyst,
  input  logic                  peak_i,
  input  logic [CW-1:0]         maxc,
  input  logic [DW-1:0]         dwell_len,
  input  logic [DW-1:0]         stagger_len,
  output logic [CW-1:0]         cnt_o
);
  seq_state_t    state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n, tgt_q, tgt_n, tgt_cap, tgt_eff;
  logic [DW-1:0] dwell_q, dwell_n, stg_q, stg_n;
  logic [IW-1:0] thr_up, thr_dn;
  logic          up_hit, dn_hit, add_go;

  always_comb begin
    thr_up = '1;
    thr_dn = '0;
    for (int i = 0; i < NPH-1; i++) begin
      if (cnt_q == CW'(i+1)) thr_up = thr_tbl[i*IW +: IW];
      if (cnt_q == CW'(i+2)) thr_dn = thr_tbl[i*IW +: IW];
    end
    up_hit  = (avg > thr_up) && (cnt_q < maxc);
    dn_hit  = (cnt_q >= CW'(2)) &&
              (({1'b0, avg} + {1'b0, hyst}) < {1'b0, thr_dn});
    add_go  = (peak_i || up_hit) && (cnt_q < maxc);
    tgt_cap = (tgt_q > maxc) ? maxc : tgt_q;
    tgt_eff = peak_i ? maxc : tgt_cap;
  end

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    tgt_n   = tgt_q;
    dwell_n = dwell_q;
    stg_n   = stg_q;
    if (cnt_q > maxc) begin
      cnt_n   = maxc;
      state_n = SEQ_IDLE;
      dwell_n = '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (add_go) begin
            cnt_n   = cnt_q + 1'b1;
            tgt_n   = peak_i ? maxc : cnt_q + 1'b1;
            stg_n   = stagger_len;
            dwell_n = '0;
            state_n = (tgt_n > cnt_n) ? SEQ_ADD : SEQ_IDLE;
          end else if (peak_i || up_hit) begin
            dwell_n = '0;
          end else if (dn_hit) begin
            if (dwell_q >= dwell_len) begin
              cnt_n   = cnt_q - 1'b1;
              dwell_n = '0;
            end else begin
              dwell_n = dwell_q + 1'b1;
            end
          end else begin
            dwell_n = '0;
          end
        end
        default: begin
          dwell_n = '0;
          tgt_n   = tgt_eff;
          if (cnt_q >= tgt_eff) begin
            state_n = SEQ_IDLE;
          end else if (stg_q == '0) begin
            cnt_n = cnt_q + 1'b1;
            stg_n = stagger_len;
            if ((cnt_q + 1'b1) >= tgt_eff) state_n = SEQ_IDLE;
          end else begin
            stg_n = stg_q - 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= CW'(1);
      tgt_q   <= CW'(1);
      dwell_q <= '0;
      stg_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      tgt_q   <= tgt_n;
      dwell_q <= dwell_n;
      stg_q   <= stg_n;
    end
  end

  assign cnt_o = cnt_q;

  // R5
  shed_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q < $past(cnt_q)) && ($past(cnt_q) <= $past(maxc)))
      |-> (cnt_q == CW'($past(cnt_q) - 1'b1)));
  // R3
  add_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > $past(cnt_q)) |-> (cnt_q == CW'($past(cnt_q) + 1'b1)));
  // R7
  add_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SEQ_IDLE) && add_go) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/pc_pw_ramp.sv
module pc_pw_ramp #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [PW-1:0] init_pw,
  input  logic [PW-1:0] ramp_step,
  output logic [PW-1:0] pw_o
);
  logic [PW-1:0] pw_q, pw_n;
  logic [PW:0]   sum;

  always_comb begin
    sum = {1'b0, pw_q} + {1'b0, ramp_step};
    if (!en_i)        pw_n = init_pw;
    else if (sum[PW]) pw_n = '1;
    else              pw_n = sum[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pw_q <= '1;
    else        pw_q <= pw_n;
  end

  assign pw_o = en_i ? pw_q : '0;

  // R9
  start_pw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_i) && $stable(init_pw)) |-> (pw_o == init_pw));
  // R9
  pw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i)) |-> (pw_o >= $past(pw_o)));
endmodule

// File: rtl/phase_count_ctrl.sv
module phase_count_ctrl #(
  parameter int NPH = 6,
  parameter int IW  = 12,
  parameter int KW  = 4,
  parameter int DW  = 8,
  parameter int PW  = 8,
  localparam int CW = $clog2(NPH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_vld,
  input  logic [IW-1:0]         smp,
  input  logic                  peak_i,
  input  logic [KW-1:0]         k_sel,
  input  logic [(NPH-1)*IW-1:0] thr_tbl,
  input  logic [IW-1:0]         hyst,
  input  logic [CW-1:0]         max_ph,
  input  logic [DW-1:0]         dwell_len,
  input  logic [DW-1:0]         stagger_len,
  input  logic [PW-1:0]         init_pw,
  input  logic [PW-1:0]         ramp_step,
  output logic [NPH-1:0]        ph_en,
  output logic [NPH*PW-1:0]     ph_pw
);
  logic [IW-1:0] avg;
  logic [CW-1:0] maxc, cnt, act;

  always_comb begin
    if (max_ph == '0)            maxc = CW'(1);
    else if (max_ph > CW'(NPH))  maxc = CW'(NPH);
    else                         maxc = max_ph;
    act = (cnt > maxc) ? maxc : cnt;
  end

  pc_avg_filter #(.IW(IW), .KW(KW)) u_avg (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
    .k_sel(k_sel), .avg(avg)
  );

  pc_sequencer #(.NPH(NPH), .IW(IW), .DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .avg(avg), .thr_tbl(thr_tbl), .hyst(hyst),
    .peak_i(peak_i), .maxc(maxc), .dwell_len(dwell_len),
    .stagger_len(stagger_len), .cnt_o(cnt)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    assign ph_en[g] = (act > CW'(g));
    pc_pw_ramp #(.PW(PW)) u_ramp (
      .clk(clk), .rst_n(rst_n), .en_i(ph_en[g]), .init_pw(init_pw),
      .ramp_step(ramp_step), .pw_o(ph_pw[g*PW +: PW])
    );
  end

  // R8
  en_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ph_en) <= int'(maxc)) && ph_en[0]);
endmodule

// File: tb/sim_phase_count_ctrl.sv
`timescale 1ns/1ps
module sim_phase_count_ctrl;
  localparam int NPH = 6, IW = 12, KW = 4, DW = 8, PW = 8, CW = 3;

  logic                  clk, rst_n, smp_vld, peak_i;
  logic [IW-1:0]         smp, hyst;
  logic [KW-1:0]         k_sel;
  logic [(NPH-1)*IW-1:0] thr_tbl;
  logic [CW-1:0]         max_ph;
  logic [DW-1:0]         dwell_len, stagger_len;
  logic [PW-1:0]         init_pw, ramp_step;
  logic [NPH-1:0]        ph_en;
  logic [NPH*PW-1:0]     ph_pw;

  int n_chk = 0;
  int n_fail = 0;

  phase_count_ctrl #(.NPH(NPH), .IW(IW), .KW(KW), .DW(DW), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .peak_i(peak_i),
    .k_sel(k_sel), .thr_tbl(thr_tbl), .hyst(hyst), .max_ph(max_ph),
    .dwell_len(dwell_len), .stagger_len(stagger_len), .init_pw(init_pw),
    .ramp_step(ramp_step), .ph_en(ph_en), .ph_pw(ph_pw)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pop();
    return $countones(ph_en);
  endfunction

  function automatic int pw_of(input int k);
    return int'(ph_pw[k*PW +: PW]);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk(ph_en == 6'b000001, "R1 enable", int'(ph_en), 1);
    chk(pw_of(0) == 255, "R1 phase0 pw", pw_of(0), 255);
    chk(ph_pw[NPH*PW-1:PW] == '0, "R1 idle pw", int'(ph_pw[NPH*PW-1:PW] != '0), 0);
  endtask

  task automatic t_add_avg();
    smp = 12'd30;
    tick(40);
    chk(ph_en == 6'b000011, "R6 from below", int'(ph_en), 3);
    smp = 12'd50;
    tick(40);
    chk(ph_en == 6'b000111, "R3 average add", int'(ph_en), 7);
    smp = 12'd30;
    tick(60);
    chk(ph_en == 6'b000011, "R6 from above", int'(ph_en), 3);
    chk(pw_of(1) == 255, "R9 settled pw", pw_of(1), 255);
  endtask

  task automatic t_avg_spike();
    k_sel = 4'd8;
    tick(2);
    smp = 12'd1000;
    tick(1);
    smp = 12'd30;
    tick(20);
    chk(ph_en == 6'b000011, "R2 spike k8", int'(ph_en), 3);
    k_sel = 4'd15;
    tick(2);
    smp = 12'd1000;
    tick(1);
    smp = 12'd30;
    tick(20);
    chk(ph_en == 6'b000011, "R2 spike k clamped", int'(ph_en), 3);
    k_sel = 4'd2;
    tick(20);
  endtask

  task automatic t_peak_stagger();
    int expc;
    stagger_len = 8'd3;
    dwell_len   = 8'd200;
    tick(1);
    peak_i = 1'b1;
    @(negedge clk);
    peak_i = 1'b0;
    #1;
    chk(ph_en == 6'b000111, "R4 first add", int'(ph_en), 7);
    chk(pw_of(2) == 200, "R9 initial pw", pw_of(2), 200);
    for (int c = 2; c <= 16; c++) begin
      @(negedge clk);
      #1;
      expc = 3 + (c - 1) / 4;
      if (expc > 6) expc = 6;
      chk(pop() == expc, "R4 stagger count", pop(), expc);
      if (c == 2)  chk(pw_of(2) == 220, "R9 ramp", pw_of(2), 220);
      if (c == 3)  chk(pw_of(2) == 240, "R9 ramp", pw_of(2), 240);
      if (c == 4)  chk(pw_of(2) == 255, "R9 saturate", pw_of(2), 255);
      if (c == 5)  chk(pw_of(3) == 200, "R9 initial pw", pw_of(3), 200);
      if (c == 13) chk(pw_of(5) == 200, "R9 initial pw", pw_of(5), 200);
      if (c == 16) chk(pw_of(5) == 255, "R9 saturate", pw_of(5), 255);
    end
    chk(ph_en == 6'b111111, "R4 index order", int'(ph_en), 63);
  endtask

  task automatic t_shed();
    int prev, cur, tlast, ndec;
    dwell_len = 8'd5;
    smp = 12'd5;
    prev = pop();
    tlast = -1;
    ndec = 0;
    for (int t = 0; t < 80; t++) begin
      @(negedge clk);
      #1;
      cur = pop();
      if (cur != prev) begin
        chk(cur == prev - 1, "R5 one step", cur, prev - 1);
        if (tlast >= 0) chk(t - tlast == 6, "R5 dwell spacing", t - tlast, 6);
        tlast = t;
        ndec++;
      end
      prev = cur;
    end
    chk(ndec == 5, "R5 step count", ndec, 5);
    chk(ph_en == 6'b000001, "R5 floor", int'(ph_en), 1);
  endtask

  task automatic t_priority();
    int prev, cur;
    bit found;
    dwell_len   = 8'd0;
    stagger_len = 8'd2;
    tick(1);
    peak_i = 1'b1;
    @(negedge clk);
    peak_i = 1'b0;
    #1;
    found = 1'b0;
    prev = pop();
    for (int c = 0; c < 80 && !found; c++) begin
      @(negedge clk);
      #1;
      cur = pop();
      if (prev == 5 && cur == 4) begin
        peak_i = 1'b1;
        @(negedge clk);
        peak_i = 1'b0;
        #1;
        chk(pop() == 5, "R7 add over shed", pop(), 5);
        found = 1'b1;
      end
      prev = cur;
    end
    chk(found, "R7 descent seen", int'(found), 1);
    tick(40);
  endtask

  task automatic t_max();
    dwell_len = 8'd255;
    smp = 12'd150;
    tick(40);
    chk(ph_en == 6'b111111, "R3 full by average", int'(ph_en), 63);
    max_ph = 3'd3;
    #1;
    chk(ph_en == 6'b000111, "R8 same cycle cap", int'(ph_en), 7);
    chk(ph_pw[NPH*PW-1:3*PW] == '0, "R9 disabled pw", int'(ph_pw[NPH*PW-1:3*PW] != '0), 0);
    tick(5);
    chk(ph_en == 6'b000111, "R8 cap holds", int'(ph_en), 7);
    peak_i = 1'b1;
    tick(1);
    peak_i = 1'b0;
    tick(3);
    chk(ph_en == 6'b000111, "R8 peak at cap", int'(ph_en), 7);
    max_ph = 3'd0;
    #1;
    chk(ph_en == 6'b000001, "R8 zero as one", int'(ph_en), 1);
    tick(3);
    max_ph = 3'd7;
    tick(20);
    chk(ph_en == 6'b111111, "R8 clamp to six", int'(ph_en), 63);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    smp_vld     = 1'b1;
    smp         = '0;
    peak_i      = 1'b0;
    k_sel       = 4'd2;
    thr_tbl     = {12'd100, 12'd80, 12'd60, 12'd40, 12'd20};
    hyst        = 12'd4;
    max_ph      = 3'd6;
    dwell_len   = 8'd10;
    stagger_len = 8'd3;
    init_pw     = 8'd200;
    ramp_step   = 8'd20;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_add_avg();
    t_avg_spike();
    t_peak_stagger();
    t_shed();
    t_priority();
    t_max();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule